// File: doc/BRIEF.md
# Bus-to-PCI Memory Window Translator

This block sits between a system bus and a PCI memory space of 4 GiB. It holds a small file of eight 32-bit control registers and uses three of them, the window map registers, to relocate three memory windows into PCI address space. A requester presents a window number and a byte offset inside that window. The block returns the translated 32-bit PCI address at once, or raises an out-of-range flag when the offset does not fit the window.

A strap input picks one of two board variants. The variant sets both the translation rule and the three window sizes. In the nibble variant, the low four bits of a map register become PCI address bits [31:28]. In the masked variant, the map register is aligned down to a multiple of the window size and used as the base. The other five registers (an identity word, a flags word and three snoop map words) are plain storage that software can read and write. The PCI transactions themselves are not part of this block.

Top module: `busmem_window_map`

## Requirements
- R1: After reset all eight registers read as zero, so every window base is zero and an in-range offset translates to itself.
- R2: The register byte offsets are: map window 0 at 0x00, map window 1 at 0x04, map window 2 at 0x08, identity at 0x0C, flags at 0x10, snoop map 0 at 0x14, snoop map 1 at 0x18, snoop map 2 at 0x1C. A full write stores all 32 bits, and a read returns the stored value.
- R3: A read strobe places data on `reg_rdata` on the next clock edge, and `rd_valid` is high during exactly that following cycle.
- R4: Any offset that is not in the R2 list is undefined. This covers offsets of 0x20 and above and offsets whose bits [1:0] are not zero. A write to an undefined offset changes nothing, and a read of one returns zero.
- R5: Only full-width accesses are honoured. A write whose byte enables are not 4'hF is ignored, and a read whose byte enables are not 4'hF returns zero.
- R6: With `alt_mode` = 0 and the offset in range, the PCI address is (map[3:0] << 28) + offset.
- R7: With `alt_mode` = 1 and the offset in range, the PCI address is (map & ~(size - 1)) + offset, truncated to 32 bits.
- R8: The window sizes for windows 0, 1 and 2 are 0x0C000000, 0x10000000 and 0x10000000 when `alt_mode` = 0, and 0x01000000, 0x04000000 and 0x08000000 when `alt_mode` = 1. An offset equal to or above the size, or a window select of 3, sets `out_of_range` and forces `pci_addr` to zero.
- R9: A write to a map register changes the translation of its window starting in the cycle right after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_mode | input | 1 | Variant strap: 0 selects nibble translation, 1 selects masked-base translation |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Register byte offset |
| reg_be | input | 4 | Byte enables; only 4'hF is honoured |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| rd_valid | output | 1 | High in the cycle after a read strobe |
| win_sel | input | 2 | Window number, 0 to 2 |
| win_off | input | 32 | Byte offset inside the selected window |
| pci_addr | output | 32 | Translated PCI memory address |
| out_of_range | output | 1 | Offset outside the window, or window number not valid |

## Verification
On every cycle the assertions check four things: the one-cycle read-valid timing, zero read data for misaligned and partial accesses, the out-of-range flag for window 3, and the low address bits that each variant must pass through unchanged from the offset. They cannot show that the right register feeds the right window, that each window has its exact size boundary, or that the upper address bits are correct. The bench's sweeps establish those: they cover all three windows under both straps, every nibble value, a spread of masked-base patterns, and offsets at 0, in the middle, at size − 1 and at the size itself.

// File: rtl/busmem_window_map.sv
module busmem_window_map #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alt_mode,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [3:0]    reg_be,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          rd_valid,
  input  logic [1:0]    win_sel,
  input  logic [31:0]   win_off,
  output logic [31:0]   pci_addr,
  output logic          out_of_range
);

  localparam logic [31:0] NIB_SZ0 = 32'h0C00_0000;
  localparam logic [31:0] NIB_SZ1 = 32'h1000_0000;
  localparam logic [31:0] NIB_SZ2 = 32'h1000_0000;
  localparam logic [31:0] MSK_SZ0 = 32'h0100_0000;
  localparam logic [31:0] MSK_SZ1 = 32'h0400_0000;
  localparam logic [31:0] MSK_SZ2 = 32'h0800_0000;

  logic [31:0] file_q [8];
  logic [2:0]  idx;
  logic        hit, full;
  logic [31:0] map_v, size_v, base_v;
  logic        sel_ok;

  assign idx  = reg_addr[4:2];
  assign hit  = (reg_addr[1:0] == 2'b00) && (reg_addr[AW-1:5] == '0);
  assign full = (reg_be == 4'hF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) file_q[i] <= '0;
    end else if (reg_wr && hit && full) begin
      file_q[idx] <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata <= '0;
      rd_valid  <= 1'b0;
    end else begin
      rd_valid <= reg_rd;
      if (reg_rd) reg_rdata <= (hit && full) ? file_q[idx] : 32'h0;
    end
  end

  always_comb begin
    case (win_sel)
      2'd0:    size_v = alt_mode ? MSK_SZ0 : NIB_SZ0;
      2'd1:    size_v = alt_mode ? MSK_SZ1 : NIB_SZ1;
      default: size_v = alt_mode ? MSK_SZ2 : NIB_SZ2;
    endcase
  end

  assign sel_ok       = (win_sel != 2'd3);
  assign map_v        = file_q[{1'b0, win_sel}];
  assign base_v       = alt_mode ? (map_v & ~(size_v - 32'd1)) : {map_v[3:0], 28'h0};
  assign out_of_range = !sel_ok || (win_off >= size_v);
  assign pci_addr     = out_of_range ? 32'h0 : base_v + win_off;

  AST_RDVALID_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> rd_valid); // R3
  AST_RDVALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !rd_valid); // R3
  AST_MISALIGNED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr[1:0] != 2'b00) |=> (reg_rdata == 32'h0)); // R4
  AST_PARTIAL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_be != 4'hF) |=> (reg_rdata == 32'h0)); // R5
  AST_NIBBLE_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!alt_mode && !out_of_range) |-> (pci_addr[27:0] == win_off[27:0])); // R6
  AST_MASKED_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_mode && !out_of_range) |-> (pci_addr[23:0] == win_off[23:0])); // R7
  AST_BAD_WINDOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (win_sel == 2'd3) |-> out_of_range); // R8

endmodule

// File: tb/tb_busmem_window_map.sv
`timescale 1ns/1ps
module tb_busmem_window_map;
  localparam int AW = 8;

  logic clk = 0, rst_n = 0, alt_mode = 0, reg_wr = 0, reg_rd = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [3:0] reg_be = 4'hF;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic rd_valid;
  logic [1:0] win_sel = '0;
  logic [31:0] win_off = '0, pci_addr;
  logic out_of_range;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] shadow [8];

  busmem_window_map #(.AW(AW)) dut (.*);

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_be = be; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0; reg_be = 4'hF;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [3:0] be, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_be = be; reg_rd = 1;
    @(negedge clk);
    reg_rd = 0; reg_be = 4'hF;
    d = reg_rdata;
    chk(rd_valid === 1'b1, "R3 rd_valid after strobe", {31'h0, rd_valid}, 32'h1);
  endtask

  function automatic logic [31:0] wsize(input int w, input bit alt);
    case (w)
      0: return alt ? 32'h0100_0000 : 32'h0C00_0000;
      1: return alt ? 32'h0400_0000 : 32'h1000_0000;
      default: return alt ? 32'h0800_0000 : 32'h1000_0000;
    endcase
  endfunction

  task automatic xlate(input int w, input logic [31:0] off, input bit alt, input logic [31:0] map, input string req);
    logic [31:0] sz, base, exp;
    bit oor;
    sz = wsize(w, alt);
    base = alt ? (map & ~(sz - 32'd1)) : (map << 28);
    oor = (off >= sz);
    exp = oor ? 32'h0 : base + off;
    win_sel = 2'(w); win_off = off;
    #1;
    chk(out_of_range === oor, {req, " flag"}, {31'h0, out_of_range}, {31'h0, oor});
    chk(pci_addr === exp, {req, " addr"}, pci_addr, exp);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      rd(AW'(i * 4), 4'hF, d);
      chk(d === 32'h0, "R1 reset read", d, 32'h0);
      shadow[i] = 32'h0;
    end
    for (int w = 0; w < 3; w++) xlate(w, 32'h0012_3450, 0, 32'h0, "R1 zero base");
    @(negedge clk);
    chk(rd_valid === 1'b0, "R3 rd_valid single cycle", {31'h0, rd_valid}, 32'h0);
    // R2 storage at each offset
    for (int i = 0; i < 8; i++) begin
      shadow[i] = 32'h1111_1111 * (i + 1) ^ 32'hA5C3_0F96;
      wr(AW'(i * 4), shadow[i], 4'hF);
    end
    for (int i = 0; i < 8; i++) begin
      rd(AW'(i * 4), 4'hF, d);
      chk(d === shadow[i], "R2 readback", d, shadow[i]);
    end
    // R4 undefined offsets
    wr(8'h20, 32'hDEAD_BEEF, 4'hF);
    wr(8'h41, 32'hDEAD_BEEF, 4'hF);
    wr(8'h02, 32'hDEAD_BEEF, 4'hF);
    wr(8'hFC, 32'hDEAD_BEEF, 4'hF);
    for (int i = 0; i < 8; i++) begin
      rd(AW'(i * 4), 4'hF, d);
      chk(d === shadow[i], "R4 undefined write ignored", d, shadow[i]);
    end
    rd(8'h20, 4'hF, d); chk(d === 32'h0, "R4 undefined read", d, 32'h0);
    rd(8'h0D, 4'hF, d); chk(d === 32'h0, "R4 misaligned read", d, 32'h0);
    // R5 partial access
    wr(8'h0C, 32'h0BAD_0BAD, 4'h7);
    wr(8'h00, 32'h0BAD_0BAD, 4'h1);
    rd(8'h0C, 4'hF, d); chk(d === shadow[3], "R5 partial write ignored", d, shadow[3]);
    rd(8'h00, 4'hF, d); chk(d === shadow[0], "R5 partial write ignored", d, shadow[0]);
    rd(8'h10, 4'h3, d); chk(d === 32'h0, "R5 partial read zero", d, 32'h0);
    // R6 nibble sweep with R8 boundaries, R9 immediacy
    alt_mode = 0;
    for (int w = 0; w < 3; w++) begin
      for (int m = 0; m < 16; m++) begin
        logic [31:0] mv, sz;
        mv = 32'h5A5A_5A50 | 32'(m);
        sz = wsize(w, 0);
        wr(AW'(w * 4), mv, 4'hF);
        xlate(w, 32'h0000_0004, 0, mv, "R9 R6 right after write");
        xlate(w, 32'h0, 0, mv, "R6 offset 0");
        xlate(w, (sz >> 1) + 32'h3, 0, mv, "R6 mid offset");
        xlate(w, sz - 32'd1, 0, mv, "R8 R6 last byte");
        xlate(w, sz, 0, mv, "R8 at size");
        xlate(w, 32'hFFFF_FFFC, 0, mv, "R8 far offset");
      end
    end
    // R7 masked sweep
    alt_mode = 1;
    for (int w = 0; w < 3; w++) begin
      for (int m = 0; m < 16; m++) begin
        logic [31:0] mv, sz;
        mv = (32'h1357_9BDF * 32'(m + 1)) ^ 32'hF0F0_F0F0;
        sz = wsize(w, 1);
        wr(AW'(w * 4), mv, 4'hF);
        xlate(w, 32'h0, 1, mv, "R7 offset 0");
        xlate(w, (sz >> 2) + 32'h11, 1, mv, "R7 mid offset");
        xlate(w, sz - 32'd1, 1, mv, "R8 R7 last byte");
        xlate(w, sz, 1, mv, "R8 at size");
      end
    end
    // R8 window 3 under both straps
    for (int a = 0; a < 2; a++) begin
      alt_mode = a[0];
      win_sel = 2'd3; win_off = 32'h0;
      #1;
      chk(out_of_range === 1'b1, "R8 window 3 flag", {31'h0, out_of_range}, 32'h1);
      chk(pci_addr === 32'h0, "R8 window 3 addr", pci_addr, 32'h0);
    end
    // R1 reset again clears
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    alt_mode = 0;
    xlate(1, 32'h0ABC_0000, 0, 32'h0, "R1 reset clears base");
    rd(8'h1C, 4'hF, d); chk(d === 32'h0, "R1 reset clears snoop", d, 32'h0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule